// File: doc/BRIEF.md
# Q4.4 Fixed-Point Adder and Multiplier with Digit Display

This block performs unsigned arithmetic on two fixed-point operands, each holding four integer bits above four fractional bits. It produces their sum at full width, so the carry out of the integer part is kept, and their full product in Q8.8 form. The integer field of the product is then turned into a seven-segment glyph that a single display digit can show.

Operands are presented with a one-cycle `in_valid` strobe and captured into an input register. Sum, product, product integer field and glyph appear in an output register on the following clock edge, marked by a one-cycle `out_valid` pulse. Between strobes the outputs hold their last result. The formats are set by two parameters, integer bits and fractional bits, with 4 and 4 as defaults.

Top module: `q44_arith_unit`

## Requirements
- R1: While `out_valid` is high, `sum_out` equals the 9-bit unsigned sum of the two captured operands, and bit 8 holds the carry.
- R2: While `out_valid` is high, `prod_out` equals the 16-bit unsigned product of the two captured operands, read as Q8.8.
- R3: While `out_valid` is high, `prod_int` equals bits [15:8] of the product, which is the integer part.
- R4: `seg_n` shows the low hex digit of `prod_int` (bits [11:8] of the product), active-low, with bit 0 = segment a through bit 6 = segment g. The digits 0 to F map to 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00, 0x10, 0x08, 0x03, 0x46, 0x21, 0x06, 0x0E.
- R5: The fractional byte of the product is dropped with no rounding. 0x28 × 0x30 (2.5 × 3.0) gives product 0x0780 and digit 7 (`seg_n` = 0x78). 0x1F × 0x1F (about 1.94 squared) gives integer 3, not 4.
- R6: If `in_valid` is high at clock edge k, `out_valid` is high for exactly the cycle after edge k+1 and carries that operand pair's results. Strobes on consecutive cycles give consecutive results, in the same order.
- R7: Operand changes while `in_valid` is low have no effect. The outputs keep their last values and `out_valid` stays low.
- R8: While `rst_n` is low at a clock edge, the outputs go to `out_valid`=0, `sum_out`=0, `prod_out`=0, `prod_int`=0 and `seg_n`=0x7F (all segments dark).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 8 | First Q4.4 operand |
| op_b | input | 8 | Second Q4.4 operand |
| out_valid | output | 1 | Result strobe, one cycle |
| sum_out | output | 9 | Sum with carry, Q5.4 |
| prod_out | output | 16 | Full product, Q8.8 |
| prod_int | output | 8 | Integer field of product |
| seg_n | output | 7 | Active-low segments, bit 0 = a |

## Verification
The bench targets several corner cases:
- 0xFF + 0xFF and 0x80 + 0x80 exercise the carry bit. A design that drops the carry would return 0xFE and 0x00.
- 0xFF × 0xFF fills the top product bits. A product register that is too narrow would lose 0xFE in the integer field.
- 0x28 × 0x30 and 0x1F × 0x1F catch integer extraction at the wrong binary point, and rounding instead of truncation. Either fault would show 0x78 as a different glyph, or show 4 instead of 3.
- Back-to-back strobes, operand changes while `in_valid` is low, and a reset after activity expose a valid pipeline that is misaligned or leaks. Such a fault would show as a result in the wrong cycle, a stale or overwritten value, or a lit display after reset.

// File: rtl/q44_pkg.sv
// Package: shared constants and the hex-to-glyph mapping for the Q4.4 unit.
// Assumes a common-anode style display: a segment is lit when its bit is 0.
package q44_pkg;

    localparam int SEG_W = 7;                       // segments a..g
    localparam logic [SEG_W-1:0] SEG_BLANK = '1;    // all dark

    // Map one hex digit to an active-low glyph, bit 0 = a, bit 6 = g.
    function automatic logic [SEG_W-1:0] hex_glyph_n(input logic [3:0] d);
        logic [SEG_W-1:0] lit;
        case (d)
            4'h0: lit = 7'b0111111;
            4'h1: lit = 7'b0000110;
            4'h2: lit = 7'b1011011;
            4'h3: lit = 7'b1001111;
            4'h4: lit = 7'b1100110;
            4'h5: lit = 7'b1101101;
            4'h6: lit = 7'b1111101;
            4'h7: lit = 7'b0000111;
            4'h8: lit = 7'b1111111;
            4'h9: lit = 7'b1101111;
            4'hA: lit = 7'b1110111;
            4'hB: lit = 7'b1111100;
            4'hC: lit = 7'b0111001;
            4'hD: lit = 7'b1011110;
            4'hE: lit = 7'b1111001;
            default: lit = 7'b1110001;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/q44_adder.sv
// Module: full-width unsigned adder for two fixed-point operands.
// Assumes both operands share one binary point; result keeps the carry.
module q44_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);

    // Zero-extend both sides so the carry lands in the top bit.
    always_comb sum = {1'b0, a} + {1'b0, b};

endmodule

// File: rtl/q44_mult.sv
// Module: unsigned array multiplier built from W shifted partial products.
// Assumes unsigned operands; the product is 2*W bits and never overflows.
module q44_mult #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);

    localparam int PW = 2 * W;

    logic [PW-1:0] acc [W+1];
    logic [PW-1:0] a_ext;

    assign a_ext  = {{W{1'b0}}, a};
    assign acc[0] = '0;

    // One row per multiplier bit: add the shifted multiplicand when the bit is set.
    for (genvar i = 0; i < W; i++) begin : g_row
        assign acc[i+1] = acc[i] + (b[i] ? (a_ext << i) : '0);
    end

    assign prod = acc[W];

endmodule

// File: rtl/q44_seg_decode.sv
// Module: turns the low hex digit of an integer field into an active-low glyph.
// Assumes the field is at least 4 bits wide; higher digits are not displayed.
module q44_seg_decode
    import q44_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic [FW-1:0]    field,
    output logic [SEG_W-1:0] seg_n
);

    logic [3:0] digit;

    // Pick the low nibble and look up its glyph.
    always_comb begin
        digit = field[3:0];
        seg_n = hex_glyph_n(digit);
    end

endmodule

// File: rtl/q44_arith_unit.sv
// Module: registered fixed-point adder/multiplier with digit display.
// Operands are captured on in_valid; results are registered one edge later
// and flagged by a one-cycle out_valid. The product fraction is truncated.
// Assumes unsigned operands and a synchronous, active-low reset.
module q44_arith_unit
    import q44_pkg::*;
#(
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [INT_BITS+FRAC_BITS-1:0]       op_a,
    input  logic [INT_BITS+FRAC_BITS-1:0]       op_b,
    output logic                                out_valid,
    output logic [INT_BITS+FRAC_BITS:0]         sum_out,
    output logic [2*(INT_BITS+FRAC_BITS)-1:0]   prod_out,
    output logic [2*INT_BITS-1:0]               prod_int,
    output logic [SEG_W-1:0]                    seg_n
);

    localparam int W    = INT_BITS + FRAC_BITS;
    localparam int PW   = 2 * W;
    localparam int IW   = 2 * INT_BITS;
    localparam int PT_LO = 2 * FRAC_BITS;   // binary point of the product

    logic [W-1:0]     a_q, b_q;
    logic             cap_vld;
    logic [W:0]       sum_c;
    logic [PW-1:0]    prod_c;
    logic [IW-1:0]    int_c;
    logic [SEG_W-1:0] seg_c;

    // Input stage: hold operands from the strobed cycle, track their validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            cap_vld <= 1'b0;
        end else begin
            cap_vld <= in_valid;
            if (in_valid) begin
                a_q <= op_a;
                b_q <= op_b;
            end
        end
    end

    q44_adder #(.W(W)) u_add (
        .a   (a_q),
        .b   (b_q),
        .sum (sum_c)
    );

    q44_mult #(.W(W)) u_mul (
        .a    (a_q),
        .b    (b_q),
        .prod (prod_c)
    );

    // Integer field sits above the product's binary point; fraction dropped.
    assign int_c = prod_c[PW-1:PT_LO];

    q44_seg_decode #(.FW(IW)) u_seg (
        .field (int_c),
        .seg_n (seg_c)
    );

    // Output stage: register results only for a valid capture, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_out   <= '0;
            prod_out  <= '0;
            prod_int  <= '0;
            seg_n     <= SEG_BLANK;
        end else begin
            out_valid <= cap_vld;
            if (cap_vld) begin
                sum_out  <= sum_c;
                prod_out <= prod_c;
                prod_int <= int_c;
                seg_n    <= seg_c;
            end
        end
    end

endmodule

// File: rtl/q44_arith_chk.sv
// Checker: temporal properties of q44_arith_unit seen at its ports.
// Assumes operand ports are driven to known values from time zero.
module q44_arith_chk #(
    parameter int INT_BITS  = 4,
    parameter int FRAC_BITS = 4
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              in_valid,
    input logic [INT_BITS+FRAC_BITS-1:0]     op_a,
    input logic [INT_BITS+FRAC_BITS-1:0]     op_b,
    input logic                              out_valid,
    input logic [INT_BITS+FRAC_BITS:0]       sum_out,
    input logic [2*(INT_BITS+FRAC_BITS)-1:0] prod_out,
    input logic [2*INT_BITS-1:0]             prod_int,
    input logic [6:0]                        seg_n
);

    localparam int W  = INT_BITS + FRAC_BITS;
    localparam int PW = 2 * W;

    // R1: sum of the operands strobed two edges earlier
    assert_sum_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sum_out == ({1'b0, $past(op_a, 2)} + {1'b0, $past(op_b, 2)}));

    // R2: full-width product of the operands strobed two edges earlier
    assert_prod_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> prod_out == (PW'($past(op_a, 2)) * PW'($past(op_b, 2))));

    // R4: every hex glyph lights at least two segments once a result exists
    assert_glyph_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(~seg_n) >= 2);

    // R6: a strobe yields out_valid two edges later
    assert_strobe_to_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R6: out_valid never appears without a strobe two edges earlier
    assert_valid_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R7: results hold while no new result is flagged
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(sum_out) && $stable(prod_out) && $stable(prod_int) && $stable(seg_n)));

    // R8: a reset edge leaves cleared outputs and a dark display
    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sum_out == '0 && prod_out == '0 && prod_int == '0 && seg_n == 7'h7F));

endmodule

bind q44_arith_unit q44_arith_chk #(
    .INT_BITS  (INT_BITS),
    .FRAC_BITS (FRAC_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .sum_out   (sum_out),
    .prod_out  (prod_out),
    .prod_int  (prod_int),
    .seg_n     (seg_n)
);

// File: tb/q44_arith_unit_tb.sv
`timescale 1ns/1ps
module q44_arith_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        out_valid;
    logic [8:0]  sum_out;
    logic [15:0] prod_out;
    logic [7:0]  prod_int;
    logic [6:0]  seg_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    q44_arith_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .sum_out   (sum_out),
        .prod_out  (prod_out),
        .prod_int  (prod_int),
        .seg_n     (seg_n)
    );

    // Operand pairs {a, b}
    localparam logic [15:0] VEC [12] = '{
        16'h2830, 16'h0000, 16'h00FF, 16'hFF00, 16'h10AB, 16'hFFFF,
        16'h8080, 16'h1F1F, 16'hF0F0, 16'h0110, 16'h7F81, 16'hC3A5
    };

    // Expected glyph, from the table in R4
    function automatic logic [6:0] exp_glyph(input logic [3:0] d);
        case (d)
            4'h0: return 7'h40;  4'h1: return 7'h79;  4'h2: return 7'h24;  4'h3: return 7'h30;
            4'h4: return 7'h19;  4'h5: return 7'h12;  4'h6: return 7'h02;  4'h7: return 7'h78;
            4'h8: return 7'h00;  4'h9: return 7'h10;  4'hA: return 7'h08;  4'hB: return 7'h03;
            4'hC: return 7'h46;  4'hD: return 7'h21;  4'hE: return 7'h06;  default: return 7'h0E;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Compare all outputs against integer-arithmetic results for a, b
    task automatic check_result(input logic [7:0] a, input logic [7:0] b);
        int s, p;
        s = int'(a) + int'(b);
        p = int'(a) * int'(b);
        check("R6 out_valid", 32'(out_valid), 32'd1);
        check("R1 sum", 32'(sum_out), 32'(s));
        check("R2 product", 32'(prod_out), 32'(p));
        check("R3 integer field", 32'(prod_int), 32'((p >> 8) & 255));
        check("R4 glyph", 32'(seg_n), 32'(exp_glyph(4'((p >> 8) & 15))));
    endtask

    // Strobe one pair and check it at the cycle the result appears
    task automatic run_pair(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); check_result(a, b);
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " R8 out_valid"}, 32'(out_valid), 32'd0);
        check({tag, " R8 sum"}, 32'(sum_out), 32'd0);
        check({tag, " R8 product"}, 32'(prod_out), 32'd0);
        check({tag, " R8 integer"}, 32'(prod_int), 32'd0);
        check({tag, " R8 glyph"}, 32'(seg_n), 32'h7F);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check_reset_state("initial");
        rst_n = 1'b1;

        // Table walk: R1..R4, R6
        for (int i = 0; i < 12; i++) begin
            run_pair(VEC[i][15:8], VEC[i][7:0]);
        end

        // R5: 2.5 x 3.0 shows 7
        run_pair(8'h28, 8'h30);
        check("R5 product 2.5x3.0", 32'(prod_out), 32'h0780);
        check("R5 glyph 7", 32'(seg_n), 32'h78);
        // R5: truncation, 3.75... shows 3 not 4
        run_pair(8'h1F, 8'h1F);
        check("R5 truncated integer", 32'(prod_int), 32'd3);
        // R1: carry kept
        run_pair(8'hFF, 8'hFF);
        check("R1 carry bit", 32'(sum_out[8]), 32'd1);

        // R6: pulse lasts one cycle
        @(negedge clk);
        check("R6 single pulse", 32'(out_valid), 32'd0);

        // R7: operand changes without strobe are ignored
        op_a = 8'h12; op_b = 8'h34;
        repeat (3) @(negedge clk);
        check("R7 no valid", 32'(out_valid), 32'd0);
        check("R7 sum held", 32'(sum_out), 32'h1FE);
        check("R7 product held", 32'(prod_out), 32'hFE01);
        check("R7 glyph held", 32'(seg_n), 32'h06);

        // R6: back-to-back strobes
        @(negedge clk); op_a = 8'h28; op_b = 8'h30; in_valid = 1'b1;
        @(negedge clk); op_a = 8'h99; op_b = 8'h17;
        @(negedge clk); in_valid = 1'b0; op_a = 8'h00; op_b = 8'h00;
        check_result(8'h28, 8'h30);
        @(negedge clk); check_result(8'h99, 8'h17);
        @(negedge clk); check("R6 back-to-back end", 32'(out_valid), 32'd0);

        // Random operands
        for (int i = 0; i < 40; i++) begin
            run_pair(8'($urandom), 8'($urandom));
        end

        // R8: reset after activity
        run_pair(8'hF7, 8'hE3);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("after use");
        rst_n = 1'b1;
        run_pair(8'h31, 8'h42);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule